// File: doc/BRIEF.md
# Shared-Bus Snoop-and-Hold Egress Port

This block is the port-side logic of one station on a shared data bus with central arbitration. For its own traffic it holds one outgoing frame, raises a request and waits for the central grant. It drives the bus only in the cycle after that grant. The outgoing bus word carries a small internal header, built from the frame's destination address, that the central lookup uses.

Every frame that another station places on the bus is copied, speculatively, into a pending slot. Each slot keeps the frame and a sequence tag, which is the number of bus frames seen since reset. Results arrive later, in bus order, on a separate 64-bit results bus. A result whose tag equals the oldest pending slot releases that slot. A forward result sends the frame to the egress side with its destination address replaced and with the queue and class of service taken from the result. A drop result simply frees the slot. When every slot is occupied the port lowers its snoop-ready flag, and frames seen in that state are not stored but counted.

Top module: `shbus_snoop_port`

## Requirements
- R1: `bus_out_valid` is high only in the cycle right after a cycle in which `bus_req` and `bus_gnt` were both high, and it is low at all other times.
- R2: Once a frame is accepted (`tx_valid` while `tx_ready`), `tx_ready` is low and `bus_req` stays high until a grant arrives. After the frame has been driven, `bus_req` is low and `tx_ready` is high again.
- R3: The driven bus word is laid out as follows: bits [255:248] hold PORT_ID, bits [247:240] hold the XOR of the six bytes of the frame's destination address (frame bits [239:192]), and bits [239:0] hold the frame.
- R4: A bus frame seen while this port is not driving is stored with a tag equal to the count, modulo 256, of all bus frames seen since reset (the port's own frames included). A bus frame seen while this port is driving is not stored.
- R5: A result whose tag differs from the oldest pending slot's tag, or that arrives while nothing is pending, leaves the pending slots unchanged and produces no egress.
- R6: A matching forward result produces `eg_valid` in the next cycle. `eg_data` is then the stored frame with bits [239:192] replaced by the result's address.
- R7: A matching drop result frees the oldest slot and produces no egress.
- R8: `snoop_ready` is low exactly when all SLOTS pending slots are occupied. A bus frame from another station seen in that state is not stored and increments `ovf_count` by one.
- R9: After reset, `bus_req`, `bus_out_valid` and `eg_valid` are low, `tx_ready` and `snoop_ready` are high, and `ovf_count` is zero.
- R10: The result word is laid out as follows: bit 63 is forward (1) or drop (0), [62:55] is the tag, [54:7] is the new destination address, [6:5] is the egress queue and [4:2] is the class of service. These last two appear on `eg_queue` and `eg_cos` with the forwarded frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the data bus and the results bus |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Local frame offered for sending |
| tx_frame | input | 240 | Local frame, destination address in [239:192] |
| tx_ready | output | 1 | Transmit holding slot is free |
| bus_req | output | 1 | Request to the central arbiter |
| bus_gnt | input | 1 | Grant from the central arbiter |
| bus_out_valid | output | 1 | This port drives the data bus this cycle |
| bus_out_data | output | 256 | Word driven onto the data bus |
| bus_in_valid | input | 1 | A frame is on the data bus |
| bus_in_data | input | 256 | Data bus contents |
| snoop_ready | output | 1 | At least one pending slot is free |
| ovf_count | output | OVF_W | Saturating count of frames lost to full slots |
| res_valid | input | 1 | Result word present |
| res_word | input | 64 | Result word |
| eg_valid | output | 1 | Forwarded frame present |
| eg_data | output | 240 | Forwarded frame with rewritten destination |
| eg_queue | output | 2 | Egress queue of the forwarded frame |
| eg_cos | output | 3 | Class of service of the forwarded frame |

## Verification
The bound checker watches the bus handshake on every cycle: no drive without the grant in the cycle before, a request that stays up until granted, and `tx_ready` low while a request is pending. It also checks the overflow counter step for each frame lost to full slots, the occupancy bound, and that any egress follows a forward result by one cycle. The bench scenarios are needed to show that tags really pair results with the right frames. Only they show stale and mismatched results being ignored, the rewritten egress contents, queue and class, the drop path, and the header layout of the port's own frames, all checked against a bench model of the pending slots.

// File: rtl/shbus_pkg.sv
package shbus_pkg;
  localparam int BUS_W   = 256;
  localparam int RES_W   = 64;
  localparam int TAG_W   = 8;
  localparam int MAC_W   = 48;
  localparam int FRAME_W = 240;
  localparam int QUEUE_W = 2;
  localparam int COS_W   = 3;
  localparam int MAC_LSB = FRAME_W - MAC_W;

  typedef struct packed {
    logic               fwd;
    logic [TAG_W-1:0]   tag;
    logic [MAC_W-1:0]   mac;
    logic [QUEUE_W-1:0] queue;
    logic [COS_W-1:0]   cos;
    logic [1:0]         spare;
  } res_word_t;

  // XOR of the six address bytes, used as the lookup hint in the header
  function automatic logic [7:0] mac_fold(input logic [MAC_W-1:0] mac);
    logic [7:0] acc;
    acc = '0;
    for (int i = 0; i < MAC_W / 8; i++) acc = acc ^ mac[i*8 +: 8];
    return acc;
  endfunction

  function automatic logic [BUS_W-1:0] build_bus_word(input logic [7:0] id,
                                                      input logic [FRAME_W-1:0] fr);
    return {id, mac_fold(fr[FRAME_W-1:MAC_LSB]), fr};
  endfunction

  function automatic logic [FRAME_W-1:0] rewrite_dst(input logic [FRAME_W-1:0] fr,
                                                     input logic [MAC_W-1:0] mac);
    return {mac, fr[MAC_LSB-1:0]};
  endfunction
endpackage

// File: rtl/shbus_tx_stage.sv
module shbus_tx_stage
  import shbus_pkg::*;
#(
  parameter logic [7:0] PORT_ID = 8'h03
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_valid,
  input  logic [FRAME_W-1:0] tx_frame,
  output logic               tx_ready,
  output logic               bus_req,
  input  logic               bus_gnt,
  output logic               bus_out_valid,
  output logic [BUS_W-1:0]   bus_out_data,
  output logic               grant_take
);
  logic               held_q;
  logic               drive_q;
  logic [FRAME_W-1:0] frame_q;

  assign tx_ready      = !held_q;
  assign bus_req       = held_q && !drive_q;
  assign grant_take    = bus_req && bus_gnt;
  assign bus_out_valid = drive_q;
  assign bus_out_data  = drive_q ? build_bus_word(PORT_ID, frame_q) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q  <= 1'b0;
      drive_q <= 1'b0;
      frame_q <= '0;
    end else begin
      drive_q <= grant_take;
      if (tx_valid && !held_q) begin
        held_q  <= 1'b1;
        frame_q <= tx_frame;
      end else if (drive_q) begin
        held_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/shbus_pend_fifo.sv
module shbus_pend_fifo #(
  parameter int SLOTS  = 4,
  parameter int DATA_W = 240,
  parameter int TAG_W  = 8,
  localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic [TAG_W-1:0]  push_tag,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic [TAG_W-1:0]  head_tag,
  output logic              empty,
  output logic              full,
  output logic [CNT_W-1:0]  count
);
  logic [DATA_W-1:0] data_mem [SLOTS];
  logic [TAG_W-1:0]  tag_mem  [SLOTS];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(SLOTS - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty     = (count == '0);
  assign full      = (count == CNT_W'(SLOTS));
  assign do_push   = push && !full;
  assign do_pop    = pop && !empty;
  assign head_data = data_mem[rd_ptr];
  assign head_tag  = tag_mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      if (do_push && !do_pop)      count <= count + CNT_W'(1);
      else if (do_pop && !do_push) count <= count - CNT_W'(1);
    end
  end

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          data_mem[s] <= '0;
          tag_mem[s]  <= '0;
        end else if (do_push && wr_ptr == PTR_W'(s)) begin
          data_mem[s] <= push_data;
          tag_mem[s]  <= push_tag;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/shbus_result_unit.sv
module shbus_result_unit
  import shbus_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               res_valid,
  input  logic [RES_W-1:0]   res_word,
  input  logic               pend_empty,
  input  logic [TAG_W-1:0]   head_tag,
  input  logic [FRAME_W-1:0] head_data,
  output logic               res_pop,
  output logic               fwd_hit,
  output logic               drop_hit,
  output logic               eg_valid,
  output logic [FRAME_W-1:0] eg_data,
  output logic [QUEUE_W-1:0] eg_queue,
  output logic [COS_W-1:0]   eg_cos
);
  res_word_t r;

  assign r        = res_word;
  assign res_pop  = res_valid && !pend_empty && (r.tag == head_tag);
  assign fwd_hit  = res_pop && r.fwd;
  assign drop_hit = res_pop && !r.fwd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eg_valid <= 1'b0;
      eg_data  <= '0;
      eg_queue <= '0;
      eg_cos   <= '0;
    end else begin
      eg_valid <= fwd_hit;
      if (fwd_hit) begin
        eg_data  <= rewrite_dst(head_data, r.mac);
        eg_queue <= r.queue;
        eg_cos   <= r.cos;
      end
    end
  end
endmodule

// File: rtl/shbus_snoop_port.sv
module shbus_snoop_port
  import shbus_pkg::*;
#(
  parameter logic [7:0] PORT_ID = 8'h03,
  parameter int         SLOTS   = 4,
  parameter int         OVF_W   = 16,
  localparam int        CNT_W   = $clog2(SLOTS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_valid,
  input  logic [239:0]       tx_frame,
  output logic               tx_ready,
  output logic               bus_req,
  input  logic               bus_gnt,
  output logic               bus_out_valid,
  output logic [255:0]       bus_out_data,
  input  logic               bus_in_valid,
  input  logic [255:0]       bus_in_data,
  output logic               snoop_ready,
  output logic [OVF_W-1:0]   ovf_count,
  input  logic               res_valid,
  input  logic [63:0]        res_word,
  output logic               eg_valid,
  output logic [239:0]       eg_data,
  output logic [1:0]         eg_queue,
  output logic [2:0]         eg_cos
);
  logic               grant_take;
  logic [TAG_W-1:0]   bus_tag_q;
  logic               foreign_ev, capture_ev, ovf_ev;
  logic               pend_empty, pend_full;
  logic [CNT_W-1:0]   pend_count;
  logic [TAG_W-1:0]   head_tag;
  logic [FRAME_W-1:0] head_data;
  logic               res_pop, fwd_hit, drop_hit;

  function automatic logic [OVF_W-1:0] sat_inc(input logic [OVF_W-1:0] v);
    return (v == '1) ? v : v + OVF_W'(1);
  endfunction

  shbus_tx_stage #(.PORT_ID(PORT_ID)) u_tx (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_frame(tx_frame),
    .tx_ready(tx_ready), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_out_valid(bus_out_valid), .bus_out_data(bus_out_data),
    .grant_take(grant_take)
  );

  assign foreign_ev  = bus_in_valid && !bus_out_valid;
  assign capture_ev  = foreign_ev && !pend_full;
  assign ovf_ev      = foreign_ev && pend_full;
  assign snoop_ready = !pend_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_tag_q <= '0;
      ovf_count <= '0;
    end else begin
      if (bus_in_valid) bus_tag_q <= bus_tag_q + TAG_W'(1);
      if (ovf_ev)       ovf_count <= sat_inc(ovf_count);
    end
  end

  shbus_pend_fifo #(.SLOTS(SLOTS), .DATA_W(FRAME_W), .TAG_W(TAG_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .push(capture_ev),
    .push_data(bus_in_data[FRAME_W-1:0]), .push_tag(bus_tag_q),
    .pop(res_pop), .head_data(head_data), .head_tag(head_tag),
    .empty(pend_empty), .full(pend_full), .count(pend_count)
  );

  shbus_result_unit u_res (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_word(res_word),
    .pend_empty(pend_empty), .head_tag(head_tag), .head_data(head_data),
    .res_pop(res_pop), .fwd_hit(fwd_hit), .drop_hit(drop_hit),
    .eg_valid(eg_valid), .eg_data(eg_data), .eg_queue(eg_queue), .eg_cos(eg_cos)
  );
endmodule

// File: rtl/shbus_snoop_port_chk.sv
module shbus_snoop_port_chk #(
  parameter int  SLOTS = 4,
  parameter int  OVF_W = 16,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_req,
  input logic             bus_gnt,
  input logic             tx_ready,
  input logic             bus_out_valid,
  input logic             res_valid,
  input logic [63:0]      res_word,
  input logic             eg_valid,
  input logic             ovf_ev,
  input logic             capture_ev,
  input logic             res_pop,
  input logic [OVF_W-1:0] ovf_count,
  input logic [CNT_W-1:0] pend_count
);
  p_drive_after_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_out_valid |-> $past(bus_req && bus_gnt));

  p_req_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req);

  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !tx_ready);

  p_egress_after_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eg_valid |-> $past(res_valid && res_word[63]));

  p_drop_no_egress_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_word[63]) |=> !eg_valid);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_ev && ovf_count != '1) |=> ovf_count == $past(ovf_count) + OVF_W'(1));

  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_count <= CNT_W'(SLOTS));

  p_pop_shrinks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_pop && !capture_ev) |=> pend_count == $past(pend_count) - CNT_W'(1));

  p_idle_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_pop && !capture_ev) |=> $stable(pend_count));
endmodule

bind shbus_snoop_port shbus_snoop_port_chk #(.SLOTS(SLOTS), .OVF_W(OVF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .tx_ready(tx_ready), .bus_out_valid(bus_out_valid), .res_valid(res_valid),
  .res_word(res_word), .eg_valid(eg_valid), .ovf_ev(ovf_ev),
  .capture_ev(capture_ev), .res_pop(res_pop), .ovf_count(ovf_count),
  .pend_count(pend_count)
);

// File: tb/shbus_snoop_port_tb_top.sv
module shbus_snoop_port_tb_top;
  localparam logic [7:0] MY_ID = 8'h03;
  localparam int NSLOT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic         tx_valid = 1'b0;
  logic [239:0] tx_frame = '0;
  logic         tx_ready, bus_req, bus_out_valid, snoop_ready, eg_valid;
  logic         bus_gnt = 1'b0;
  logic [255:0] bus_out_data;
  logic         frn_valid = 1'b0;
  logic [255:0] frn_data = '0;
  logic         bus_in_valid;
  logic [255:0] bus_in_data;
  logic [15:0]  ovf_count;
  logic         res_valid = 1'b0;
  logic [63:0]  res_word = '0;
  logic [239:0] eg_data;
  logic [1:0]   eg_queue;
  logic [2:0]   eg_cos;

  assign bus_in_valid = bus_out_valid | frn_valid;
  assign bus_in_data  = bus_out_valid ? bus_out_data : frn_data;

  shbus_snoop_port dut_i (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_frame(tx_frame),
    .tx_ready(tx_ready), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_out_valid(bus_out_valid), .bus_out_data(bus_out_data),
    .bus_in_valid(bus_in_valid), .bus_in_data(bus_in_data),
    .snoop_ready(snoop_ready), .ovf_count(ovf_count),
    .res_valid(res_valid), .res_word(res_word), .eg_valid(eg_valid),
    .eg_data(eg_data), .eg_queue(eg_queue), .eg_cos(eg_cos)
  );

  int checks = 0;
  int errors = 0;
  int tag_cnt = 0;
  int exp_ovf = 0;
  logic [7:0]   pend_tag[$];
  logic [239:0] pend_frm[$];
  logic [239:0] exp_dat[$];
  logic [4:0]   exp_qc[$];

  task automatic chk(input bit ok, input string req,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fold8(input logic [47:0] m);
    logic [7:0] x = 8'h00;
    for (int b = 0; b < 6; b++) x ^= m[b*8 +: 8];
    return x;
  endfunction

  function automatic logic [239:0] rand_frame();
    logic [255:0] w;
    for (int k = 0; k < 8; k++) w[k*32 +: 32] = $urandom;
    return w[239:0];
  endfunction

  // egress monitor: compare every forwarded frame with the model (R6, R10)
  always @(negedge clk) begin
    if (rst_n && eg_valid) begin
      if (exp_dat.size() == 0) begin
        chk(1'b0, "R5 unexpected egress", 256'(eg_valid), 256'(0));
      end else begin
        logic [239:0] d;
        logic [4:0]   qc;
        d  = exp_dat.pop_front();
        qc = exp_qc.pop_front();
        chk(eg_data === d, "R6 egress data", 256'(eg_data), 256'(d));
        chk(eg_queue === qc[4:3], "R10 egress queue", 256'(eg_queue), 256'(qc[4:3]));
        chk(eg_cos === qc[2:0], "R10 egress cos", 256'(eg_cos), 256'(qc[2:0]));
      end
    end
  end

  task automatic send_foreign(input logic [239:0] fr, output logic [7:0] tg);
    @(negedge clk);
    frn_valid = 1'b1;
    frn_data  = {8'h07, fold8(fr[239:192]), fr};
    tg = tag_cnt[7:0];
    if (pend_tag.size() < NSLOT) begin  // R4 capture model
      pend_tag.push_back(tg);
      pend_frm.push_back(fr);
    end else begin
      exp_ovf++;                        // R8 overflow model
    end
    tag_cnt++;
    @(negedge clk);
    frn_valid = 1'b0;
  endtask

  task automatic send_own(input logic [239:0] fr, output logic [7:0] tg);
    int wait_n;
    @(negedge clk);
    chk(tx_ready === 1'b1, "R2 ready before load", 256'(tx_ready), 256'(1));
    tx_valid = 1'b1;
    tx_frame = fr;
    @(negedge clk);
    tx_valid = 1'b0;
    wait_n = $urandom_range(0, 2);
    for (int w = 0; w <= wait_n; w++) begin
      chk(bus_req === 1'b1, "R2 request held", 256'(bus_req), 256'(1));
      chk(tx_ready === 1'b0, "R2 not ready while held", 256'(tx_ready), 256'(0));
      chk(bus_out_valid === 1'b0, "R1 no drive before grant", 256'(bus_out_valid), 256'(0));
      if (w < wait_n) @(negedge clk);
    end
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0;
    chk(bus_out_valid === 1'b1, "R1 drive after grant", 256'(bus_out_valid), 256'(1));
    chk(bus_out_data === {MY_ID, fold8(fr[239:192]), fr}, "R3 bus word",
        bus_out_data, {MY_ID, fold8(fr[239:192]), fr});
    tg = tag_cnt[7:0];
    tag_cnt++;
    @(negedge clk);
    chk(bus_out_valid === 1'b0, "R1 single drive cycle", 256'(bus_out_valid), 256'(0));
    chk(bus_req === 1'b0 && tx_ready === 1'b1, "R2 released after send",
        256'({bus_req, tx_ready}), 256'(2'b01));
  endtask

  // result word: [63] fwd, [62:55] tag, [54:7] mac, [6:5] queue, [4:2] cos (R10)
  task automatic send_result(input bit fwd, input logic [7:0] tg);
    logic [47:0] mac;
    logic [1:0]  q;
    logic [2:0]  c;
    bit          hit;
    mac = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
    q   = 2'($urandom);
    c   = 3'($urandom);
    @(negedge clk);
    res_valid = 1'b1;
    res_word  = {fwd, tg, mac, q, c, 2'b00};
    hit = (pend_tag.size() > 0) && (pend_tag[0] == tg);
    if (hit) begin
      logic [239:0] f;
      void'(pend_tag.pop_front());
      f = pend_frm.pop_front();
      if (fwd) begin
        exp_dat.push_back({mac, f[191:0]});
        exp_qc.push_back({q, c});
      end
    end
    @(negedge clk);
    res_valid = 1'b0;
    if (!hit)
      chk(eg_valid === 1'b0, "R5 unmatched result ignored", 256'(eg_valid), 256'(0));
    else if (!fwd)
      chk(eg_valid === 1'b0, "R7 drop gives no egress", 256'(eg_valid), 256'(0));
    else
      chk(eg_valid === 1'b1, "R6 forward gives egress", 256'(eg_valid), 256'(1));
  endtask

  task automatic check_fill(input string tagname);
    bit full_exp;
    full_exp = (pend_tag.size() == NSLOT);
    chk(snoop_ready === !full_exp, {"R8 snoop_ready ", tagname},
        256'(snoop_ready), 256'(!full_exp));
    chk(ovf_count === 16'(exp_ovf), {"R8 overflow count ", tagname},
        256'(ovf_count), 256'(exp_ovf));
  endtask

  bit done = 1'b0;

  initial begin
    logic [7:0] tags[8];
    int seed_sink;
    seed_sink = $urandom(32'd7341);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(bus_req === 1'b0, "R9 bus_req", 256'(bus_req), 256'(0));
    chk(bus_out_valid === 1'b0, "R9 bus_out_valid", 256'(bus_out_valid), 256'(0));
    chk(eg_valid === 1'b0, "R9 eg_valid", 256'(eg_valid), 256'(0));
    chk(tx_ready === 1'b1 && snoop_ready === 1'b1, "R9 ready flags",
        256'({tx_ready, snoop_ready}), 256'(2'b11));
    chk(ovf_count === 16'd0, "R9 ovf_count", 256'(ovf_count), 256'(0));

    // directed: result with nothing pending is ignored (R5)
    send_result(1'b1, 8'h00);

    // directed: fill past capacity, overflowed tags must not match (R4 R8)
    for (int i = 0; i < 6; i++) send_foreign(rand_frame(), tags[i]);
    check_fill("after directed fill");
    for (int i = 0; i < 6; i++) send_result(1'b1, tags[i]);
    check_fill("after directed drain");

    // directed: own frame interleaved, its result must be ignored (R4)
    send_foreign(rand_frame(), tags[0]);
    send_own(rand_frame(), tags[1]);
    send_foreign(rand_frame(), tags[2]);
    send_result(1'b1, tags[0]);
    send_result(1'b1, tags[1]);
    send_result(1'b0, tags[2]);

    // constrained random rounds
    for (int r = 0; r < 60; r++) begin
      int n;
      n = $urandom_range(1, 7);
      for (int i = 0; i < n; i++) begin
        if ($urandom_range(0, 3) == 0) send_own(rand_frame(), tags[i]);
        else                           send_foreign(rand_frame(), tags[i]);
        if ($urandom_range(0, 2) == 0) @(negedge clk);
      end
      check_fill("after burst");
      for (int i = 0; i < n; i++) begin
        if ($urandom_range(0, 4) == 0) send_result(1'b1, tags[i] + 8'd100);
        send_result(bit'($urandom_range(0, 1)), tags[i]);
      end
      check_fill("after results");
    end

    repeat (2) @(negedge clk);
    chk(exp_dat.size() == 0, "R6 all forwards seen", 256'(exp_dat.size()), 256'(0));
    chk(pend_tag.size() == 0 && snoop_ready === 1'b1, "R4 slots drained",
        256'(pend_tag.size()), 256'(0));
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule